// File: doc/BRIEF.md
# Dot-Matrix Character Plotter

The block draws one character into a point-addressed display memory. It accepts a character code and the top-left corner of a character cell. It then fetches the packed dot image for that code from a built-in glyph generator and copies the image into a hold register. From the hold register it emits one point command per cell position. Each point command carries an X coordinate, a Y coordinate and a flag that selects writing or erasing.

The scan runs column by column, starting at the top-left corner. Inside a column the Y coordinate steps down. At the end of each column, Y returns to the origin row and X moves one place to the right. Every position in the 9 x 14 cell is emitted: 1 dots are written and 0 dots are erased, so the character fully replaces what was on the screen beneath it.

Each point waits for the downstream point controller to report completion before the scan moves on. A one-cycle done pulse marks the end of the cell.

Top module: `glyph_plotter`

## Requirements
- R1: After reset, ptValid and done are 0 and startReady is 1.
- R2: A request is taken on a clock edge where startValid and startReady are both 1. In the next cycle ptValid is 1 and the point sits at (originX, originY). startReady stays 0 until the cell is finished.
- R3: While ptValid is 1 and ptDone is 0, ptX, ptY and ptWrite hold their values. The scan advances only on an edge where ptValid and ptDone are both 1.
- R4: Inside a column, each next point has ptY one lower than the previous point, modulo 512, and the same ptX. A column is 14 points tall.
- R5: After the 14th point of a column, ptY returns to originY and ptX becomes one greater than before, modulo 512.
- R6: A cell is 9 columns, which is 126 points. After the handshake of the last point, ptValid is 0 and done is 1 for exactly one cycle, and startReady is 1 again.
- R7: For point number p (0 to 125, in scan order), ptWrite (1 = write, 0 = erase) equals bit (p mod 7) of the code XOR bit 0 of (p div 7).
- R8: A startValid pulse while a cell is being drawn is ignored. The running cell continues with its own code and origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request to draw a character |
| startCode | input | 7 | Character code of the request |
| originX | input | 9 | X of the top-left cell corner |
| originY | input | 9 | Y of the top-left cell corner |
| startReady | output | 1 | Block is idle and will take a request |
| ptValid | output | 1 | A point command is presented |
| ptX | output | 9 | X coordinate of the point |
| ptY | output | 9 | Y coordinate of the point |
| ptWrite | output | 1 | 1 writes the point, 0 erases it |
| ptDone | input | 1 | Downstream has finished the presented point |
| done | output | 1 | One-cycle pulse after the final point of the cell |

## Verification
The hardest cases to reach are the coordinate wrap in both axes, a late completion on the last point of a column, and a request that arrives mid-cell. The bench sweeps all 128 codes. It places origins close to 0 and 511, so columns run across the Y wrap and the cell runs across the X wrap. The completion delay changes from point to point, including on the column boundaries. During the wait on the first point of some runs, the bench raises a second request with a different code and origin.

// File: rtl/glyph_plotter_pkg.sv
package glyph_plotter_pkg;
  typedef struct packed {
    logic load;     // capture origin and glyph image
    logic stepRow;  // next point in same column
    logic stepCol;  // first point of next column
  } plotStrobe_t;
endpackage

// File: rtl/glyph_rom.sv
module glyph_rom #(
  parameter int CODE_W = 7,
  parameter int CELL_N = 126
) (
  input  logic [CODE_W-1:0] code,
  output logic [CELL_N-1:0] image
);
  for (genvar i = 0; i < CELL_N; i++) begin : g_dot
    localparam int SEL  = i % CODE_W;
    localparam int BAND = (i / CODE_W) % 2;
    assign image[i] = code[SEL] ^ BAND[0];
  end
endmodule

// File: rtl/plotter_ctrl.sv
module plotter_ctrl
  import glyph_plotter_pkg::*;
#(
  parameter int COLS = 9,
  parameter int ROWS = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        ptDone,
  output logic        startReady,
  output logic        ptValid,
  output logic        done,
  output plotStrobe_t strobe
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  typedef enum logic {S_IDLE, S_EMIT} state_t;
  state_t state;
  logic [RW-1:0] rowCnt;
  logic [CW-1:0] colCnt;
  logic handshake, lastRow, lastCol, finish;

  assign handshake = (state == S_EMIT) && ptDone;
  assign lastRow   = rowCnt == ROW_LAST;
  assign lastCol   = colCnt == COL_LAST;
  assign finish    = handshake && lastRow && lastCol;

  always_comb begin
    strobe.load    = (state == S_IDLE) && startValid;
    strobe.stepRow = handshake && !lastRow;
    strobe.stepCol = handshake && lastRow && !lastCol;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      rowCnt <= '0;
      colCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (strobe.load) begin
        state  <= S_EMIT;
        rowCnt <= '0;
        colCnt <= '0;
      end else if (strobe.stepRow) begin
        rowCnt <= rowCnt + 1'b1;
      end else if (strobe.stepCol) begin
        rowCnt <= '0;
        colCnt <= colCnt + 1'b1;
      end else if (finish) begin
        state <= S_IDLE;
      end
    end
  end

  assign startReady = state == S_IDLE;
  assign ptValid    = state == S_EMIT;
endmodule

// File: rtl/plotter_datapath.sv
module plotter_datapath
  import glyph_plotter_pkg::*;
#(
  parameter int CODE_W  = 7,
  parameter int COORD_W = 9,
  parameter int CELL_N  = 126
) (
  input  logic               clk,
  input  logic               rstN,
  input  plotStrobe_t        strobe,
  input  logic [CODE_W-1:0]  startCode,
  input  logic [COORD_W-1:0] originX,
  input  logic [COORD_W-1:0] originY,
  output logic [COORD_W-1:0] ptX,
  output logic [COORD_W-1:0] ptY,
  output logic               ptWrite
);
  logic [CELL_N-1:0]  romImage;
  logic [CELL_N-1:0]  holdImage;
  logic [COORD_W-1:0] curX, curY, baseY;

  glyph_rom #(.CODE_W(CODE_W), .CELL_N(CELL_N)) u_rom (
    .code (startCode),
    .image(romImage)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdImage <= '0;
      curX      <= '0;
      curY      <= '0;
      baseY     <= '0;
    end else if (strobe.load) begin
      holdImage <= romImage;
      curX      <= originX;
      curY      <= originY;
      baseY     <= originY;
    end else if (strobe.stepRow) begin
      holdImage <= holdImage >> 1;
      curY      <= curY - 1'b1;
    end else if (strobe.stepCol) begin
      holdImage <= holdImage >> 1;
      curX      <= curX + 1'b1;
      curY      <= baseY;
    end
  end

  assign ptX     = curX;
  assign ptY     = curY;
  assign ptWrite = holdImage[0];
endmodule

// File: rtl/glyph_plotter.sv
module glyph_plotter
  import glyph_plotter_pkg::*;
#(
  parameter int CODE_W  = 7,
  parameter int COORD_W = 9,
  parameter int COLS    = 9,
  parameter int ROWS    = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startValid,
  input  logic [CODE_W-1:0]  startCode,
  input  logic [COORD_W-1:0] originX,
  input  logic [COORD_W-1:0] originY,
  output logic               startReady,
  output logic               ptValid,
  output logic [COORD_W-1:0] ptX,
  output logic [COORD_W-1:0] ptY,
  output logic               ptWrite,
  input  logic               ptDone,
  output logic               done
);
  localparam int CELL_N = COLS * ROWS;
  plotStrobe_t strobe;

  plotter_ctrl #(.COLS(COLS), .ROWS(ROWS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .ptDone(ptDone),
    .startReady(startReady), .ptValid(ptValid), .done(done), .strobe(strobe)
  );

  plotter_datapath #(.CODE_W(CODE_W), .COORD_W(COORD_W), .CELL_N(CELL_N)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startCode(startCode),
    .originX(originX), .originY(originY),
    .ptX(ptX), .ptY(ptY), .ptWrite(ptWrite)
  );
endmodule

// File: rtl/glyph_plotter_checks.sv
module glyph_plotter_checks #(
  parameter int COORD_W = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic               startReady,
  input logic               ptValid,
  input logic [COORD_W-1:0] ptX,
  input logic [COORD_W-1:0] ptY,
  input logic               ptWrite,
  input logic               ptDone,
  input logic               done
);
  p_hold_point_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ptValid && !ptDone) |=> (ptValid && $stable(ptX) && $stable(ptY) && $stable(ptWrite)));

  p_row_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ptValid && ptDone) |=> (!(ptValid && ptX == $past(ptX)) || ptY == $past(ptY) - 1'b1));

  p_col_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ptValid && ptDone) |=> (!(ptValid && ptX != $past(ptX)) || ptX == $past(ptX) + 1'b1));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!ptValid && startReady));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    ptValid |-> !startReady);
endmodule

bind glyph_plotter glyph_plotter_checks #(.COORD_W(COORD_W)) u_checks (
  .clk(clk), .rstN(rstN), .startReady(startReady), .ptValid(ptValid),
  .ptX(ptX), .ptY(ptY), .ptWrite(ptWrite), .ptDone(ptDone), .done(done)
);

// File: tb/tb_glyph_plotter.sv
`timescale 1ns/1ps
module tb_glyph_plotter;
  logic clk = 0;
  logic rstN = 0;
  logic startValid = 0;
  logic [6:0] startCode = '0;
  logic [8:0] originX = '0, originY = '0;
  logic startReady, ptValid, ptWrite, ptDone, done;
  logic [8:0] ptX, ptY;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  glyph_plotter dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startCode(startCode),
    .originX(originX), .originY(originY), .startReady(startReady),
    .ptValid(ptValid), .ptX(ptX), .ptY(ptY), .ptWrite(ptWrite),
    .ptDone(ptDone), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expDot(input int code, input int p);
    return ((code >> (p % 7)) & 1) ^ ((p / 7) & 1);
  endfunction

  task automatic checkPoint(input int code, input int ox, input int oy, input int p);
    chk("R2 ptValid", ptValid, 1);
    chk("R5 ptX", ptX, (ox + p / 14) % 512);
    chk("R4 ptY", ptY, (oy - (p % 14) + 512) % 512);
    chk("R7 ptWrite", ptWrite, expDot(code, p));
  endtask

  task automatic drawCell(input int code, input int ox, input int oy,
                          input int dly, input bit intrude);
    startValid = 1; startCode = 7'(code); originX = 9'(ox); originY = 9'(oy);
    @(negedge clk);
    startValid = 0;
    chk("R2 startReady busy", startReady, 0);
    for (int p = 0; p < 126; p++) begin
      int d = (p * 7 + code + dly) % 4;
      if (dly == 0) d = 0;
      ptDone = 0;
      checkPoint(code, ox, oy, p);
      if (intrude && p == 0) begin
        startValid = 1; startCode = ~7'(code); originX = 9'(ox + 100); originY = 9'(oy + 50);
        if (d == 0) d = 1;
      end
      for (int k = 0; k < d; k++) begin
        @(negedge clk);
        checkPoint(code, ox, oy, p);  // R3: held while not done
      end
      if (intrude && p == 0) startValid = 0;  // R8 request dropped
      ptDone = 1;
      @(negedge clk);
    end
    ptDone = 0;
    chk("R6 done pulse", done, 1);
    chk("R6 ptValid low", ptValid, 0);
    chk("R6 startReady", startReady, 1);
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
  endtask

  initial begin
    ptDone = 0;
    repeat (3) @(negedge clk);
    chk("R1 ptValid", ptValid, 0);
    chk("R1 done", done, 0);
    chk("R1 startReady", startReady, 1);
    rstN = 1;
    @(negedge clk);
    chk("R1 idle after reset", startReady, 1);
    for (int c = 0; c < 128; c++) begin
      int ox = (c % 4 == 0) ? 505 : (c * 37) % 512;
      int oy = (c % 3 == 0) ? 5 : (c * 53) % 512;
      drawCell(c, ox, oy, c % 2, (c % 16) == 3);  // R8 on some runs
    end
    drawCell(127, 511, 0, 1, 1'b0);  // both axes wrap
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule